// File: doc/BRIEF.md
# Write-Status Polling Read Responder

This block sits between a nonvolatile array's read path and its data pins. It builds the byte returned on every host read. While no program or erase operation is running, it passes the array word through unchanged. While an operation is running, it returns a status word instead, so the host can poll the pins to find out when the operation has finished.

The status word carries two independent completion indicators. The top data bit returns the inverted top bit of the byte last loaded for programming. This happens only when the read hits the address being programmed. The bit just below it inverts once per completed read for as long as the operation lasts. A host can watch either indicator. The same block decides whether the data pins are driven at all, from chip enable, output enable, write enable and the device reset pin.

The result is registered once, so a read condition sampled at one clock edge appears on the outputs after that edge. Only the top bit of the last loaded byte feeds the block, because no other bit of that byte reaches the status word.

Top module: `pollResponder`

## Requirements
- R1: While `rstN` is low, `dataOe` and `dataOut` are both 0.
- R2: A read condition exists when `ceN`=0, `oeN`=0, `weN`=1 and `pinRstN`=1. After each clock edge, `dataOe` equals the read condition sampled at that edge. Whenever `dataOe` is 0, `dataOut` is all zeros, which stands for released pins.
- R3: With `busy`=0 and a read condition present, `dataOut` equals the `arrayData` sampled at the previous edge.
- R4: With `busy`=1, `progOp`=1 and `rdAddr`==`lastAddr`, bit DATA_W-1 of `dataOut` is the inverse of `lastMsb`.
- R5: With `busy`=1, bit DATA_W-1 of `dataOut` is 0 when the address misses `lastAddr` or `progOp`=0 (erase).
- R6: With `busy`=1, bits DATA_W-3 down to 0 of `dataOut` are 0.
- R7: With `busy`=1, bit DATA_W-2 of `dataOut` during the n-th read of the current operation (n counted from 0) equals n mod 2. It is constant for the whole length of one read.
- R8: The toggle state is 0 whenever `busy` is 0. The first read of every new operation therefore returns 0 on bit DATA_W-2.
- R9: A read counts once when its read condition is lost while `busy`=1. This holds whether chip enable rises, output enable rises, both rise, or the reset pin falls. Changing the address in the middle of a read does not count.
- R10: On the edge after `busy` falls during a held read, `dataOut` returns the true `arrayData`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous active-low block reset |
| ceN | input | 1 | Chip enable, active low |
| oeN | input | 1 | Output enable, active low |
| weN | input | 1 | Write enable, active low |
| pinRstN | input | 1 | Device reset pin, active low; low releases the pins |
| busy | input | 1 | A program or erase operation is running |
| progOp | input | 1 | 1 when the running operation is a byte program, 0 for erase |
| rdAddr | input | ADDR_W | Address of the current read |
| arrayData | input | DATA_W | Word read from the array at `rdAddr` |
| lastAddr | input | ADDR_W | Address of the byte last loaded for programming |
| lastMsb | input | 1 | Top bit of the byte last loaded for programming |
| dataOut | output | DATA_W | Registered read data or status word |
| dataOe | output | 1 | Registered pin drive enable |

## Verification
The assertions assume that every input is sampled once per clock edge and is stable around that edge. They also assume that `lastAddr` and `lastMsb` do not change during an operation, and that reset is applied with the read condition absent. The bench drives all inputs on the falling clock edge and loads the operation's address and data before raising `busy`. It never ends a read on the same edge on which `busy` changes. The bench sweeps all sixteen combinations of the pin controls, then runs arithmetic address and data sequences through idle reads, program polling and erase polling, using all four ways of ending a read.

// File: rtl/pollPkg.sv
package pollPkg;
  // Strobes handed from the control side to the datapath.
  typedef struct packed {
    logic readEn;      // read condition present this cycle
    logic showStatus;  // an operation is running: substitute status
    logic progOp;      // running operation is a byte program
    logic togBit;      // current toggle state
  } pollCtl_t;
endpackage

// File: rtl/pollCtl.sv
module pollCtl
  import pollPkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     ceN,
  input  logic     oeN,
  input  logic     weN,
  input  logic     pinRstN,
  input  logic     busy,
  input  logic     progOp,
  output pollCtl_t ctl
);
  logic readEn;
  logic readPrev;
  logic readEnd;
  logic togQ;

  assign readEn  = !ceN && !oeN && weN && pinRstN;
  // A read is counted when it ends, so the value seen during it is stable.
  assign readEnd = readPrev && !readEn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      readPrev <= 1'b0;
      togQ     <= 1'b0;
    end else begin
      readPrev <= readEn;
      if (!busy)        togQ <= 1'b0;
      else if (readEnd) togQ <= !togQ;
    end
  end

  always_comb begin
    ctl.readEn     = readEn;
    ctl.showStatus = busy;
    ctl.progOp     = progOp;
    ctl.togBit     = togQ;
  end
endmodule

// File: rtl/pollData.sv
module pollData
  import pollPkg::*;
#(
  parameter int ADDR_W = 18,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  pollCtl_t          ctl,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic [DATA_W-1:0] arrayData,
  input  logic [ADDR_W-1:0] lastAddr,
  input  logic              lastMsb,
  output logic [DATA_W-1:0] dataOut,
  output logic              dataOe
);
  localparam int POLL_BIT = DATA_W - 1;
  localparam int TOG_BIT  = DATA_W - 2;

  logic              addrHit;
  logic [DATA_W-1:0] statusWord;
  logic [DATA_W-1:0] nextWord;

  assign addrHit = (rdAddr == lastAddr);

  for (genvar b = 0; b < DATA_W; b++) begin : g_stat
    if (b == POLL_BIT) begin : g_poll
      assign statusWord[b] = ctl.progOp && addrHit && !lastMsb;
    end else if (b == TOG_BIT) begin : g_tog
      assign statusWord[b] = ctl.togBit;
    end else begin : g_zero
      assign statusWord[b] = 1'b0;
    end
  end

  always_comb begin
    if (!ctl.readEn)         nextWord = '0;
    else if (ctl.showStatus) nextWord = statusWord;
    else                     nextWord = arrayData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataOut <= '0;
      dataOe  <= 1'b0;
    end else begin
      dataOut <= nextWord;
      dataOe  <= ctl.readEn;
    end
  end
endmodule

// File: rtl/pollResponder.sv
module pollResponder
  import pollPkg::*;
#(
  parameter int ADDR_W = 18,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ceN,
  input  logic              oeN,
  input  logic              weN,
  input  logic              pinRstN,
  input  logic              busy,
  input  logic              progOp,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic [DATA_W-1:0] arrayData,
  input  logic [ADDR_W-1:0] lastAddr,
  input  logic              lastMsb,
  output logic [DATA_W-1:0] dataOut,
  output logic              dataOe
);
  pollCtl_t ctl;

  pollCtl ctl_i (
    .clk(clk), .rstN(rstN), .ceN(ceN), .oeN(oeN), .weN(weN),
    .pinRstN(pinRstN), .busy(busy), .progOp(progOp), .ctl(ctl)
  );

  pollData #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) data_i (
    .clk(clk), .rstN(rstN), .ctl(ctl), .rdAddr(rdAddr),
    .arrayData(arrayData), .lastAddr(lastAddr), .lastMsb(lastMsb),
    .dataOut(dataOut), .dataOe(dataOe)
  );
endmodule

// File: rtl/pollResponderChk.sv
module pollResponderChk #(
  parameter int ADDR_W = 18,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              ceN,
  input logic              oeN,
  input logic              weN,
  input logic              pinRstN,
  input logic              busy,
  input logic              progOp,
  input logic [ADDR_W-1:0] rdAddr,
  input logic [DATA_W-1:0] arrayData,
  input logic [ADDR_W-1:0] lastAddr,
  input logic              lastMsb,
  input logic [DATA_W-1:0] dataOut,
  input logic              dataOe
);
  logic readCond;
  assign readCond = !ceN && !oeN && weN && pinRstN;

  AST_OE_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    readCond |=> dataOe) else $error("oe"); // R2
  AST_OE_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    !readCond |=> !dataOe) else $error("release"); // R2
  AST_RESET_QUIET: assert property (@(posedge clk)
    !rstN |-> (!dataOe && dataOut == '0)) else $error("reset"); // R1
  AST_IDLE_PASS: assert property (@(posedge clk) disable iff (!rstN)
    (readCond && !busy) |=> dataOut == $past(arrayData)) else $error("pass"); // R3
  AST_LOW_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (readCond && busy) |=> dataOut[DATA_W-3:0] == '0) else $error("low"); // R6
  AST_POLL_INV: assert property (@(posedge clk) disable iff (!rstN)
    (readCond && busy && progOp && rdAddr == lastAddr) |=> dataOut[DATA_W-1] == !$past(lastMsb))
    else $error("poll"); // R4
  AST_TOG_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (readCond && busy && $past(readCond) && $past(busy)) |=> $stable(dataOut[DATA_W-2]))
    else $error("hold"); // R7
endmodule

bind pollResponder pollResponderChk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk_i (
  .clk(clk), .rstN(rstN), .ceN(ceN), .oeN(oeN), .weN(weN), .pinRstN(pinRstN),
  .busy(busy), .progOp(progOp), .rdAddr(rdAddr), .arrayData(arrayData),
  .lastAddr(lastAddr), .lastMsb(lastMsb), .dataOut(dataOut), .dataOe(dataOe)
);

// File: tb/pollResponder_tb.sv
`timescale 1ns/1ps
module pollResponder_tb_top;
  localparam int AW = 18;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          ceN = 1'b1, oeN = 1'b1, weN = 1'b1, pinRstN = 1'b1;
  logic          busy = 1'b0, progOp = 1'b0;
  logic [AW-1:0] rdAddr = '0, lastAddr = '0;
  logic [DW-1:0] arrayData = '0;
  logic          lastMsb = 1'b0;
  logic [DW-1:0] dataOut;
  logic          dataOe;

  int vectors = 0;
  int miscompares = 0;
  int opReads = 0;

  always #10 clk = !clk;

  pollResponder #(.ADDR_W(AW), .DATA_W(DW)) dut_i (
    .clk(clk), .rstN(rstN), .ceN(ceN), .oeN(oeN), .weN(weN), .pinRstN(pinRstN),
    .busy(busy), .progOp(progOp), .rdAddr(rdAddr), .arrayData(arrayData),
    .lastAddr(lastAddr), .lastMsb(lastMsb), .dataOut(dataOut), .dataOe(dataOe)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  function automatic logic [DW-1:0] expWord(input logic [AW-1:0] a, input logic [DW-1:0] d);
    logic [DW-1:0] w;
    if (!busy) return d;
    w = '0;
    w[DW-1] = progOp && (a == lastAddr) && !lastMsb;
    w[DW-2] = opReads[0];
    return w;
  endfunction

  // One read: open, check twice (R7 stability), close by endMode, check release.
  task automatic readCycle(input logic [AW-1:0] a, input logic [DW-1:0] d,
                           input int endMode, input string req);
    logic [DW-1:0] e;
    @(negedge clk);
    ceN = 1'b0; oeN = 1'b0; weN = 1'b1; pinRstN = 1'b1; rdAddr = a; arrayData = d;
    e = expWord(a, d);
    @(negedge clk);
    chk({req, " oe"}, 16'(dataOe), 16'd1);
    chk(req, 16'(dataOut), 16'(e));
    @(negedge clk);
    chk({req, " R7 held"}, 16'(dataOut), 16'(e));
    case (endMode)
      0: ceN = 1'b1;
      1: oeN = 1'b1;
      2: begin ceN = 1'b1; oeN = 1'b1; end
      default: pinRstN = 1'b0;
    endcase
    @(negedge clk);
    chk("R2 release oe", 16'(dataOe), 16'd0);
    chk("R2 release data", 16'(dataOut), 16'd0);
    if (busy) opReads++; // R9 each ending counts once
  endtask

  initial begin
    #4000000;
    miscompares++;
    $display("FAIL watchdog actual=running expected=done");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 oe", 16'(dataOe), 16'd0);
    chk("R1 data", 16'(dataOut), 16'd0);
    rstN = 1'b1;

    // R2: every combination of the four pin controls, idle.
    for (int c = 0; c < 16; c++) begin
      @(negedge clk);
      ceN = c[0]; oeN = c[1]; weN = c[2]; pinRstN = c[3];
      arrayData = 8'h3C ^ 8'(c * 17);
      @(negedge clk);
      chk("R2 decode", 16'(dataOe), (c == 12) ? 16'd1 : 16'd0);
      chk("R2 data", 16'(dataOut), (c == 12) ? 16'(arrayData) : 16'd0);
    end

    // R3: idle pass-through sweep.
    for (int i = 0; i < 64; i++)
      readCycle(AW'(i * 4099 + 7), DW'(i * 37 + 5), i % 4, "R3 idle");

    // R4 R5 R6 R7 R9: program polling, both values of the loaded top bit.
    for (int op = 0; op < 2; op++) begin
      @(negedge clk);
      progOp = 1'b1; lastAddr = AW'(18'h15A5A + op * 333); lastMsb = op[0];
      opReads = 0; busy = 1'b1;
      for (int i = 0; i < 24; i++)
        readCycle((i % 2 == 0) ? lastAddr : lastAddr ^ AW'(1 << (i % AW)),
                  DW'(i * 53 + 1), i % 4, (i % 2 == 0) ? "R4 hit" : "R5 miss");
      // R9: address change inside one read does not count.
      @(negedge clk);
      ceN = 1'b0; oeN = 1'b0; rdAddr = lastAddr; pinRstN = 1'b1;
      @(negedge clk);
      chk("R9 before move", 16'(dataOut[DW-2]), 16'(opReads[0]));
      rdAddr = lastAddr + 1'b1;
      @(negedge clk);
      chk("R9 after move", 16'(dataOut[DW-2]), 16'(opReads[0]));
      chk("R5 moved miss", 16'(dataOut[DW-1]), 16'd0);
      // R10: completion inside the held read.
      arrayData = 8'h96;
      busy = 1'b0;
      @(negedge clk);
      chk("R10 true data", 16'(dataOut), 16'h96);
      ceN = 1'b1; oeN = 1'b1;
      @(negedge clk);
      readCycle(AW'(op + 5), DW'(8'hC3), 2, "R10 idle after");
    end

    // R8: fresh erase operation starts toggle at 0; R5 bit 7 low on erase.
    @(negedge clk);
    progOp = 1'b0; lastAddr = 18'h00ABC; lastMsb = 1'b0; opReads = 0; busy = 1'b1;
    readCycle(18'h00ABC, 8'hFF, 0, "R8 first read");
    for (int i = 0; i < 16; i++)
      readCycle(18'h00ABC, DW'(i * 11), i % 4, "R5 erase");
    @(negedge clk);
    busy = 1'b0;
    @(negedge clk);
    busy = 1'b1; opReads = 0;
    readCycle(18'h00001, 8'h55, 1, "R8 restart");
    readCycle(18'h00001, 8'h55, 2, "R7 second");
    @(negedge clk);
    busy = 1'b0;
    finishRun();
  end
endmodule